// File: doc/BRIEF.md
# Bi-Phase-Level Line Encoder

This block turns a serial bit stream into a single bi-phase-level line signal, in which every bit occupies one cell made of two equal halves. A one is sent as a high half followed by a low half, which gives a falling edge in the middle of the cell. A zero is sent as a low half followed by a high half, which gives a rising edge in the middle of the cell. The block drives the encoded line on a true output and on a complemented output. Both outputs come from registers that load on the same clock edge.

The block runs from one clock at twice the bit rate. The caller raises a one-cycle cell-start strobe at the start of each cell. The data input is captured on that edge and sets the level of both halves. On the next clock edge the line moves to the opposite level, which is the second half of the cell. If no new strobe follows, the line keeps its second-half level until the next cell begins. A synchronous active-low reset puts the line in its idle state, with the true output low and the complement high.

Top module: `manchester_enc`

## Requirements
- R1: While reset (rst_n = 0) is sampled low on a clock edge, line_out becomes 0 and line_out_n becomes 1 on that edge.
- R2: A one captured on a cell-start edge drives line_out high (1) for the first half-cell after that edge and low (0) for the half-cell after the next edge.
- R3: A zero captured on a cell-start edge drives line_out low (0) for the first half-cell and high (1) for the second half-cell.
- R4: data_in is sampled only on edges where cell_start is 1. A change of data_in during the second half of a cell does not affect the line.
- R5: line_out_n is at all times the exact logical inverse of line_out. Both outputs change on the same clock edge.
- R6: After reset is released, the line stays idle (line_out = 0) until the first cell-start strobe.
- R7: When no cell-start strobe follows a second half-cell, line_out holds its second-half level until the next strobe.
- R8: A cell-start strobe in the first half of a cell ends that cell early. The new bit's first half begins on that edge.
- R9: Asserting reset in the middle of a cell returns the line to idle on the next clock edge, whatever the cell's phase.
- R10: Back-to-back cells carry one bit per two clock cycles. Each bit can be recovered by comparing its two halves: high then low gives 1, low then high gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, at twice the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| cell_start | input | 1 | One-cycle strobe that opens a new bit cell |
| data_in | input | 1 | Serial data bit, sampled with cell_start |
| line_out | output | 1 | Encoded line, true polarity |
| line_out_n | output | 1 | Encoded line, complemented |

## Verification
The assertions assume that cell_start stays low while reset is held. They also assume that data_in is valid on every edge where cell_start is 1, because only those edges define a cell. The stimulus changes inputs only on the falling clock edge and keeps the strobe at 0 throughout reset. It deliberately toggles data_in in the second half of each cell, so the sampling rule is exercised rather than assumed. Gaps between cells, early strobes and a reset in the middle of a cell are driven on purpose, so the hold and restart properties both see their antecedents.

// File: rtl/manchester_enc_pkg.sv
package manchester_enc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } half_phase_t;

  localparam logic IDLE_LINE = 1'b0;

endpackage

// File: rtl/manchester_bit_latch.sv
module manchester_bit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_start,
  input  logic data_in,
  output logic cell_bit
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cell_bit <= 1'b0;
    end else if (cell_start) begin
      cell_bit <= data_in;
    end
  end

endmodule

// File: rtl/manchester_phase_ctrl.sv
module manchester_phase_ctrl
  import manchester_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cell_start,
  output half_phase_t phase
);

  half_phase_t phase_nx;

  always_comb begin
    phase_nx = phase;
    if (cell_start) begin
      phase_nx = PH_FIRST;
    end else begin
      case (phase)
        PH_FIRST:  phase_nx = PH_SECOND;
        PH_SECOND: phase_nx = PH_SECOND;
        default:   phase_nx = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phase_nx;
    end
  end

endmodule

// File: rtl/manchester_line_drv.sv
module manchester_line_drv
  import manchester_enc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cell_start,
  input  logic        data_in,
  input  logic        cell_bit,
  input  half_phase_t phase,
  output logic        line_out,
  output logic        line_out_n
);

  logic level_nx;

  // A new cell puts its bit on the line at once; the next edge flips it.
  always_comb begin
    level_nx = line_out;
    if (cell_start) begin
      level_nx = data_in;
    end else if (phase == PH_FIRST) begin
      level_nx = ~cell_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_out   <= IDLE_LINE;
      line_out_n <= ~IDLE_LINE;
    end else begin
      line_out   <= level_nx;
      line_out_n <= ~level_nx;
    end
  end

endmodule

// File: rtl/manchester_enc.sv
module manchester_enc
  import manchester_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cell_start,
  input  logic data_in,
  output logic line_out,
  output logic line_out_n
);

  logic        cell_bit;
  half_phase_t phase;

  manchester_bit_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .data_in    (data_in),
    .cell_bit   (cell_bit)
  );

  manchester_phase_ctrl u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .phase      (phase)
  );

  manchester_line_drv u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .data_in    (data_in),
    .cell_bit   (cell_bit),
    .phase      (phase),
    .line_out   (line_out),
    .line_out_n (line_out_n)
  );

endmodule

// File: rtl/manchester_enc_chk.sv
module manchester_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic cell_start,
  input logic data_in,
  input logic line_out,
  input logic line_out_n
);

  // R1: reset drives the idle levels
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (line_out == 1'b0 && line_out_n == 1'b1));

  // R5: outputs are complementary
  a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
    line_out_n == ~line_out);

  // R2, R3: first half follows the sampled bit
  a_r2_first_half: assert property (@(posedge clk) disable iff (!rst_n)
    cell_start |=> line_out == $past(data_in));

  // R3, R4: second half is the inverse of the bit sampled one edge earlier
  a_r3_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cell_start) && !cell_start) |=> line_out == ~$past(data_in, 2));

  // R7: line holds when no cell is in its first half
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cell_start && !$past(cell_start)) |=> $stable(line_out));

endmodule

bind manchester_enc manchester_enc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cell_start (cell_start),
  .data_in    (data_in),
  .line_out   (line_out),
  .line_out_n (line_out_n)
);

// File: tb/manchester_enc_tb_top.sv
module manchester_enc_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cell_start = 1'b0;
  logic data_in = 1'b0;
  logic line_out;
  logic line_out_n;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  manchester_enc dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cell_start (cell_start),
    .data_in    (data_in),
    .line_out   (line_out),
    .line_out_n (line_out_n)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_line(input string req, input logic exp);
    check(req, line_out, exp);
    check("R5", line_out_n, ~exp);
  endtask

  // Called at a falling edge; sends one cell and then gap idle cycles.
  task automatic send_bit(input logic b, input int gap);
    logic h1;
    logic h2;
    cell_start = 1'b1;
    data_in    = b;
    @(negedge clk);
    h1 = line_out;
    check_line(b ? "R2" : "R3", b);
    cell_start = 1'b0;
    data_in    = ~b;             // R4: wiggle during second half
    @(negedge clk);
    h2 = line_out;
    check_line(b ? "R2" : "R3", ~b);
    check("R10", (h1 && !h2) ? 1'b1 : 1'b0, b);
    for (int g = 0; g < gap; g++) begin
      data_in = lfsr[g % 16];
      @(negedge clk);
      check_line("R7", ~b);
    end
  endtask

  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_line("R1", 1'b0);
    rst_n = 1'b1;
    data_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_line("R6", 1'b0);
    end

    // Exhaustive pairs of consecutive bits, with and without gaps.
    for (int p = 0; p < 4; p++) begin
      for (int gp = 0; gp < 3; gp++) begin
        send_bit(p[1], gp);
        send_bit(p[0], gp);
      end
    end

    // Pseudo-random back-to-back stream (R10).
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr_step(lfsr);
      send_bit(lfsr[0], (i % 7 == 0) ? 1 : 0);
    end

    // R8: early strobe restarts the cell with a new one.
    cell_start = 1'b1; data_in = 1'b1;
    @(negedge clk);
    check_line("R8", 1'b1);
    cell_start = 1'b1; data_in = 1'b1;
    @(negedge clk);
    check_line("R8", 1'b1);
    cell_start = 1'b0; data_in = 1'b0;
    @(negedge clk);
    check_line("R8", 1'b0);

    // R9: reset during a first half returns to idle.
    cell_start = 1'b1; data_in = 1'b1;
    @(negedge clk);
    check_line("R9", 1'b1);
    cell_start = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check_line("R9", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_line("R9", 1'b0);

    // R9: reset during a second half.
    cell_start = 1'b1; data_in = 1'b0;
    @(negedge clk);
    cell_start = 1'b0;
    @(negedge clk);
    check_line("R3", 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check_line("R9", 1'b0);
    rst_n = 1'b1;
    send_bit(1'b0, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule